// File: doc/BRIEF.md
# External Bus Write-Cycle Sequencer

This block runs single write accesses on an asynchronous external memory bus. A write request carries a zone index, a 19-bit address and 16-bit data. The block captures these values, then steps the bus through three phases in a fixed order: a setup phase (lead), a strobe phase (active) and a hold phase (trail). It drives an active-low chip-select per zone, the address bus, an active-low write strobe, an always-inactive read strobe, a read/write direction line, and the data driver as a value plus an output enable. The pad ring combines the value and the enable into the bidirectional data pins. Every tick of `clk` is one tick of the internal timing clock.

Each phase length comes from its own configuration input. The values are sampled when a request is accepted. An optional ready input can stretch the strobe phase. The block also makes the bus clock, either at the tick rate or at half of it. In half-rate mode an access must start its lead phase on a rising edge of the bus clock. When the next tick would not be one, the block inserts one alignment tick first. Outside an access the address bus keeps the last address it drove.

Top module: `xbus_write_seq`

## Requirements
- R1: After acceptance, the lead phase lasts `lead_cfg`+1 ticks and is followed by the active phase. The active phase lasts `act_cfg`+1 ticks when not stretched, then comes the trail phase of `trail_cfg` ticks, which may be zero. All fields are 3-bit unsigned.
- R2: In the lead, active and trail ticks, only `cs_n[zone]` is low, where `zone` is the index captured at acceptance. In every other tick all `cs_n` bits are high.
- R3: `we_n` is low in exactly the active-phase ticks and high in every other tick.
- R4: `rnw` is low in the lead, active and trail ticks and high otherwise. `d_oe` is high only in active and trail ticks, and `d_out` then equals the captured write data.
- R5: `bus_addr` takes the captured address from the first lead tick. It keeps that value during later idle and alignment ticks until the next access reaches its lead phase. It is 0 after reset.
- R6: With `half_rate`=0, `bclk` stays 1 and every tick is a rising-edge tick. With `half_rate`=1, `bclk` inverts on every tick, and ticks with `bclk`=1 are rising-edge ticks.
- R7: In half-rate mode the first lead tick always has `bclk`=1. A request accepted while `bclk`=1 gets exactly one alignment tick first. In that tick every strobe, chip-select and direction output is inactive and `busy` is high.
- R8: With `rdy_en`=1, `ready` (active high) is sampled in the last active tick. Each sample of 0 adds one more active tick.
- R9: With `rdy_en`=0, `ready` has no effect on any output.
- R10: A request (`req`=1) is accepted only while idle. `busy` is high from the tick after acceptance through the last trail tick. `done` is high for exactly the one tick after that.
- R11: Changes to the configuration inputs, address, data or zone after acceptance do not affect the running access.
- R12: `rd_n` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock; one tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_rate | input | 1 | 1: bus clock at half the tick rate |
| rdy_en | input | 1 | 1: honour the ready input |
| lead_cfg | input | 3 | Lead length minus one |
| act_cfg | input | 3 | Active length minus one |
| trail_cfg | input | 3 | Trail length |
| req | input | 1 | Write request |
| zone | input | 2 | Zone index of the request |
| addr | input | 19 | Write address |
| wdata | input | 16 | Write data |
| ready | input | 1 | External ready, active high |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-tick completion pulse |
| bclk | output | 1 | Bus clock level |
| cs_n | output | 3 | Per-zone chip-select, active low |
| we_n | output | 1 | Write strobe, active low |
| rd_n | output | 1 | Read strobe, held inactive |
| rnw | output | 1 | Direction, low for write |
| bus_addr | output | 19 | Address bus |
| d_out | output | 16 | Data bus value |
| d_oe | output | 1 | Data bus output enable |

## Verification
The bench builds the block with its defaults: three zones, 3-bit phase fields, a 19-bit address and 16-bit data. This covers the whole phase-length range, from the one-tick lead and active phases with an empty trail up to long settings. Using three zones makes the top zone index select the last chip-select bit, while the unused fourth index value stays unreachable in the tests. Runs in half-rate mode start from both bus-clock phases, so both the aligned case and the alignment-tick case occur.

// File: rtl/xws_pkg.sv
package xws_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_ALIGN = 3'd1,
    S_LEAD  = 3'd2,
    S_ACT   = 3'd3,
    S_TRAIL = 3'd4
  } xws_state_e;
endpackage

// File: rtl/xws_bclk_gen.sv
module xws_bclk_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic half_rate,
  output logic bclk,
  output logic align_need
);
  logic ph_q, ph_d;

  always_comb begin
    ph_d = half_rate ? ~ph_q : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= 1'b0;
    else        ph_q <= ph_d;
  end

  assign bclk       = ph_q;
  // next tick is a falling edge when the divided clock is high now
  assign align_need = half_rate & ph_q;

  a_r6_half_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    half_rate |=> (bclk != $past(bclk)));
  a_r6_full_high: assert property (@(posedge clk) disable iff (!rst_n)
    !half_rate |=> bclk);
endmodule

// File: rtl/xws_phase_seq.sv
module xws_phase_seq
  import xws_pkg::*;
#(
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          align_need,
  input  logic [PW-1:0] lead_in,
  input  logic [PW-1:0] act_in,
  input  logic [PW-1:0] trail_in,
  input  logic          rdy_en_in,
  input  logic          ready,
  output logic          accept,
  output xws_state_e    state,
  output logic          done
);
  xws_state_e    state_q, state_d;
  logic [PW-1:0] cnt_q, cnt_d;
  logic [PW-1:0] act_q, trail_q;
  logic          ren_q;
  logic          done_q, done_d;
  logic          hold_act;

  assign accept   = (state_q == S_IDLE) && req;
  assign hold_act = ren_q && !ready;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    unique case (state_q)
      S_IDLE: if (accept) begin
        state_d = align_need ? S_ALIGN : S_LEAD;
        cnt_d   = lead_in;
      end
      S_ALIGN: state_d = S_LEAD;
      S_LEAD: begin
        if (cnt_q == '0) begin
          state_d = S_ACT;
          cnt_d   = act_q;
        end else cnt_d = cnt_q - 1'b1;
      end
      S_ACT: begin
        if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
        else if (!hold_act) begin
          if (trail_q == '0) begin
            state_d = S_IDLE;
            done_d  = 1'b1;
          end else begin
            state_d = S_TRAIL;
            cnt_d   = trail_q - 1'b1;
          end
        end
      end
      S_TRAIL: begin
        if (cnt_q == '0) begin
          state_d = S_IDLE;
          done_d  = 1'b1;
        end else cnt_d = cnt_q - 1'b1;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= '0;
      trail_q <= '0;
      ren_q   <= 1'b0;
    end else if (accept) begin
      act_q   <= act_in;
      trail_q <= trail_in;
      ren_q   <= rdy_en_in;
    end
  end

  assign state = state_q;
  assign done  = done_q;

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_stretch: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_ACT && cnt_q == '0 && ren_q && !ready) |=> (state_q == S_ACT));
  a_r9_no_stretch: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_ACT && cnt_q == '0 && !ren_q) |=> (state_q != S_ACT));
  a_r7_align_once: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_ALIGN) |=> (state_q == S_LEAD));
endmodule

// File: rtl/xbus_write_seq.sv
module xbus_write_seq
  import xws_pkg::*;
#(
  parameter int ZONES = 3,
  parameter int AW    = 19,
  parameter int DW    = 16,
  parameter int PW    = 3,
  localparam int ZW   = (ZONES > 1) ? $clog2(ZONES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             half_rate,
  input  logic             rdy_en,
  input  logic [PW-1:0]    lead_cfg,
  input  logic [PW-1:0]    act_cfg,
  input  logic [PW-1:0]    trail_cfg,
  input  logic             req,
  input  logic [ZW-1:0]    zone,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic             ready,
  output logic             busy,
  output logic             done,
  output logic             bclk,
  output logic [ZONES-1:0] cs_n,
  output logic             we_n,
  output logic             rd_n,
  output logic             rnw,
  output logic [AW-1:0]    bus_addr,
  output logic [DW-1:0]    d_out,
  output logic             d_oe
);
  xws_state_e    state;
  logic          accept, align_need;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] data_q;
  logic [ZW-1:0] zone_q;
  logic          in_access, any_cs;

  xws_bclk_gen u_bclk (
    .clk        (clk),
    .rst_n      (rst_n),
    .half_rate  (half_rate),
    .bclk       (bclk),
    .align_need (align_need)
  );

  xws_phase_seq #(.PW(PW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .align_need (align_need),
    .lead_in    (lead_cfg),
    .act_in     (act_cfg),
    .trail_in   (trail_cfg),
    .rdy_en_in  (rdy_en),
    .ready      (ready),
    .accept     (accept),
    .state      (state),
    .done       (done)
  );

  // request fields captured at acceptance; the address bus only moves
  // when the lead phase begins
  logic [AW-1:0] pend_addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_addr_q <= '0;
      data_q      <= '0;
      zone_q      <= '0;
    end else if (accept) begin
      pend_addr_q <= addr;
      data_q      <= wdata;
      zone_q      <= zone;
    end
  end

  always_comb begin
    addr_d = addr_q;
    if (accept && !align_need) addr_d = addr;
    else if (state == S_ALIGN) addr_d = pend_addr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  assign in_access = (state == S_LEAD) || (state == S_ACT) || (state == S_TRAIL);

  for (genvar z = 0; z < ZONES; z++) begin : g_cs
    assign cs_n[z] = ~(in_access && (zone_q == ZW'(z)));
  end

  assign any_cs   = ~&cs_n;
  assign busy     = (state != S_IDLE);
  assign we_n     = ~(state == S_ACT);
  assign rd_n     = 1'b1;
  assign rnw      = ~in_access;
  assign d_oe     = (state == S_ACT) || (state == S_TRAIL);
  assign d_out    = data_q;
  assign bus_addr = addr_q;

  a_r4_oe_while_write: assert property (@(posedge clk) disable iff (!rst_n)
    d_oe |-> !rnw);
  a_r7_lead_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(any_cs) |-> bclk);
  a_r5_addr_still: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && state != S_ALIGN) |=> $stable(bus_addr));
  a_r3_strobe_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> any_cs);
  a_r12_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_n);
endmodule

// File: tb/tb_xbus_write_seq.sv
module tb_xbus_write_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        half_rate, rdy_en, req, ready;
  logic [2:0]  lead_cfg, act_cfg, trail_cfg;
  logic [1:0]  zone;
  logic [18:0] addr;
  logic [15:0] wdata;
  logic        busy, done, bclk, we_n, rd_n, rnw, d_oe;
  logic [2:0]  cs_n;
  logic [18:0] bus_addr;
  logic [15:0] d_out;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  logic [18:0] last_addr;

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  xbus_write_seq dut (
    .clk(clk), .rst_n(rst_n), .half_rate(half_rate), .rdy_en(rdy_en),
    .lead_cfg(lead_cfg), .act_cfg(act_cfg), .trail_cfg(trail_cfg),
    .req(req), .zone(zone), .addr(addr), .wdata(wdata), .ready(ready),
    .busy(busy), .done(done), .bclk(bclk), .cs_n(cs_n), .we_n(we_n),
    .rd_n(rd_n), .rnw(rnw), .bus_addr(bus_addr), .d_out(d_out), .d_oe(d_oe)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", rq, what, cyc, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; half_rate = 0; rdy_en = 0; req = 0; ready = 0;
    lead_cfg = 0; act_cfg = 0; trail_cfg = 0; zone = 0; addr = 0; wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n == 3'b111, "R2", "cs_n reset", 32'(cs_n), 32'h7);
    chk(we_n && rnw && !d_oe, "R4", "controls reset", {29'd0, we_n, rnw, d_oe}, 32'h6);
    chk(bus_addr == 0, "R5", "addr reset", 32'(bus_addr), 0);
    chk(!busy && !done, "R10", "handshake reset", {30'd0, busy, done}, 0);
    last_addr = 0;
  endtask

  // one write access, checked tick by tick
  task automatic t_write(input int zn, input int ad, input int dt,
                         input int L, input int A, input int T,
                         input bit half, input bit ren, input int stall,
                         input bit poke, input int pre);
    int nal, lead0, act0, trl0, fin, stl, pb;
    logic [2:0] ecs;
    half_rate = half;
    repeat (pre) @(negedge clk);
    zone = 2'(zn); addr = 19'(ad); wdata = 16'(dt);
    lead_cfg = 3'(L); act_cfg = 3'(A); trail_cfg = 3'(T);
    rdy_en = ren; ready = 1'b0; req = 1'b1;
    nal   = (half && bclk) ? 1 : 0;
    stl   = ren ? stall : 0;
    lead0 = nal; act0 = lead0 + L + 1; trl0 = act0 + A + 1 + stl; fin = trl0 + T;
    ecs   = ~(3'b001 << zn);
    pb    = bclk;
    @(posedge clk);
    for (int k = 0; k <= fin + 2; k++) begin
      bit in_acc, in_act, in_dat;
      @(negedge clk);
      if (k == 0) begin
        req = 1'b0;
        // R11: scramble every captured input after acceptance
        addr = 19'h7_1234; wdata = 16'hdead; zone = 2'(2 - zn);
        lead_cfg = 3'(7 - L); act_cfg = 3'(7 - A); trail_cfg = 3'(7 - T); rdy_en = ~ren;
      end
      if (poke && k == act0) begin req = 1'b1; addr = 19'h5_5555; end
      if (poke && k == act0 + 1) req = 1'b0;
      ready = ren ? ((k - act0) >= A + stl) : 1'b0;
      in_acc = (k >= lead0) && (k < fin);
      in_act = (k >= act0) && (k < trl0);
      in_dat = (k >= act0) && (k < fin);
      chk(cs_n == (in_acc ? ecs : 3'b111), "R2", "cs_n", 32'(cs_n), 32'(in_acc ? ecs : 3'b111));
      chk(we_n == !in_act, "R3", "we_n", 32'(we_n), 32'(!in_act));
      chk(rnw == !in_acc, "R4", "rnw", 32'(rnw), 32'(!in_acc));
      chk(d_oe == in_dat, "R4", "d_oe", 32'(d_oe), 32'(in_dat));
      if (in_dat) chk(d_out == 16'(dt), "R11", "d_out", 32'(d_out), dt);
      chk(bus_addr == ((k >= lead0) ? 19'(ad) : last_addr), "R5", "bus_addr",
          32'(bus_addr), 32'((k >= lead0) ? 19'(ad) : last_addr));
      chk(busy == (k < fin), "R10", "busy", 32'(busy), 32'(k < fin));
      chk(done == (k == fin), "R10", "done", 32'(done), 32'(k == fin));
      chk(rd_n == 1'b1, "R12", "rd_n", 32'(rd_n), 1);
      if (half) begin
        chk(bclk != pb, "R6", "bclk toggle", 32'(bclk), 32'(!pb));
        if (k == lead0) chk(bclk == 1'b1, "R7", "lead on rising tick", 32'(bclk), 1);
      end else chk(bclk == 1'b1, "R6", "bclk full rate", 32'(bclk), 1);
      pb = bclk;
    end
    last_addr = 19'(ad);
  endtask

  initial begin
    t_reset();
    t_write(0, 'h00100, 'h1111, 0, 0, 0, 0, 0, 0, 0, 0);  // R1 minimum
    t_write(2, 'h7ffff, 'ha5a5, 2, 3, 2, 0, 0, 0, 0, 1);  // R1 R2 top zone
    t_write(1, 'h12345, 'h0f0f, 7, 7, 3, 0, 0, 0, 0, 0);  // R1 long phases
    t_write(1, 'h0aaaa, 'h5555, 1, 1, 1, 1, 0, 0, 0, 0);  // R7 half rate
    t_write(0, 'h05555, 'h3c3c, 0, 2, 0, 1, 0, 0, 0, 1);  // R7 other phase
    t_write(2, 'h00042, 'hbeef, 1, 0, 1, 1, 0, 0, 0, 2);  // R7
    t_write(1, 'h0beef, 'hcafe, 1, 1, 1, 0, 1, 3, 0, 0);  // R8 stretch 3
    t_write(0, 'h01234, 'h8001, 0, 0, 2, 1, 1, 1, 0, 1);  // R8 half rate
    t_write(2, 'h04321, 'h1234, 1, 2, 1, 0, 0, 5, 0, 0);  // R9 ready ignored
    t_write(0, 'h33333, 'h7777, 1, 3, 1, 0, 0, 0, 1, 0);  // R10 req while busy
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired at cycle %0d: actual hung expected finished", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule